// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Write-Collision Guard

This block is a serial peripheral that moves one byte at a time. It can act as the bus master or as a slave, and it serves either clock phase. A CPU reaches it through a simple single-cycle register bus that has a control register, a status register and a data register. A byte written to the data register is loaded into the shifter. In master mode that write also starts a transfer. When eight bits have moved, the byte received from the line is copied into a separate receive buffer and the transfer-done flag is raised.

The main purpose of the block is to guard the shifter. A data write that arrives while a transfer is under way is dropped, and the transfer in flight finishes with its original byte. The dropped write raises a collision flag, which is status only and never drives the interrupt. The window in which a write counts as a collision depends on the mode and on the clock phase. Software clears both flags by reading the status register and then reading the data register.

Register map: address 0 is control (bit 0 selects master, bit 1 selects clock phase 1). Address 1 is status (bit 7 is the done flag, bit 6 is the collision flag, and the other bits read 0). Address 2 is data (a write loads the transmit byte, a read returns the receive buffer). SCK idles low.

Top module: `spi_wcol_ctl`

## Requirements
- R1: In master mode, a data write while no transfer runs starts an 8-bit transfer. The byte goes out on mosi_o MSB first, and sck_o toggles every DIV clock cycles. With phase 0 each bit is sampled on the rising SCK edge. With phase 1 each bit is sampled on the falling SCK edge.
- R2: In master mode, a data write during a transfer is discarded. The transfer finishes with the original byte, and the collision flag (status bit 6) is set.
- R3: On the edge that completes the eighth bit, the received byte enters the receive buffer and the done flag (status bit 7) is set. A data read returns that buffer.
- R4: irq is high exactly while the done flag is set. A collision never raises irq.
- R5: In slave mode with phase 0, a data write while ss_n_i is high is accepted, and its MSB appears on miso_o once ss_n_i goes low. Any data write while ss_n_i is low is a collision and leaves the outgoing byte unchanged.
- R6: In slave mode with phase 1, pulling ss_n_i low alone keeps miso_o at 0. A data write before the first SCK edge is accepted. The first SCK edge puts the MSB on miso_o. A data write from that edge until the eighth bit is a collision.
- R7: A status read taken while a flag is set, followed directly by a data read, clears both flags. This holds whether or not the transfer has finished.
- R8: If the access after the status read is a data write, or is any access other than a data read, the flags are unchanged and the sequence must restart.
- R9: After reset the flags are 0, control is 0 (slave, phase 0), irq is low, sck_o is low and miso_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| irq | output | 1 | Transfer-done interrupt |
| sck_o | output | 1 | Master serial clock |
| mosi_o | output | 1 | Master serial data out |
| miso_i | input | 1 | Master serial data in |
| sck_i | input | 1 | Slave serial clock in |
| mosi_i | input | 1 | Slave serial data in |
| ss_n_i | input | 1 | Slave select, active low |
| miso_o | output | 1 | Slave serial data out, 0 when deselected |

## Verification
The master path is run with a table of bytes, using both clock phases and looped back from mosi to miso. The table mixes alternating, single-bit and all-ones patterns, so that a swapped bit order, a wrong sampling edge or a missing bit each gives a distinct mismatch. Collision writes are placed at several points: in the middle of a master transfer, while the slave is selected before any clock in phase 0, and just after the first clock in phase 1. Each of these tells a correct window apart from one that is too wide or too narrow. The clear sequence is tried three ways: in its proper order, with a data write as the second step, and with an unrelated read between the steps.

// File: rtl/spi_wcol_ctl.sv
module spi_wcol_ctl #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       sck_o,
  output logic       mosi_o,
  input  logic       miso_i,
  input  logic       sck_i,
  input  logic       mosi_i,
  input  logic       ss_n_i,
  output logic       miso_o
);
  localparam int HW = $clog2(DIV) + 1;

  logic       is_master, ph;
  logic       spif, wcol, armed;
  logic [7:0] sh, rxbuf;
  logic       obit;
  logic [2:0] bitcnt;
  logic       m_busy, s_busy;
  logic [3:0] ecnt;
  logic [HW-1:0] hc;
  logic [2:0] sck_q, ss_q;
  logic [1:0] mosi_q;

  wire ss_s   = ss_q[1];
  wire ss_fall = ~ss_q[1] & ss_q[2];
  wire s_rise = sck_q[1] & ~sck_q[2];
  wire s_fall = ~sck_q[1] & sck_q[2];
  wire tick   = m_busy && hc == '0;
  wire lead   = is_master ? (tick & ~sck_o) : (~ss_s & s_rise);
  wire trail  = is_master ? (tick & sck_o) : (~ss_s & s_fall);
  wire sample = ph ? trail : lead;
  wire launch = ph ? lead : trail;
  wire din    = is_master ? miso_i : mosi_q[1];
  wire done   = sample && bitcnt == 3'd7;
  wire active = is_master ? m_busy : (ph ? s_busy : ~ss_s);
  wire dwr    = bus_sel & bus_we & (bus_addr == 2'd2);
  wire drd    = bus_sel & ~bus_we & (bus_addr == 2'd2);
  wire srd    = bus_sel & ~bus_we & (bus_addr == 2'd1);
  wire coll   = dwr & active;
  wire load   = dwr & ~active;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {6'b0, ph, is_master};
      2'd1:    bus_rdata = {spif, wcol, 6'b0};
      2'd2:    bus_rdata = rxbuf;
      default: bus_rdata = 8'h00;
    endcase
  end

  assign irq    = spif;
  assign mosi_o = obit;
  assign miso_o = (~is_master & ~ss_s) ? obit : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      ss_q   <= '1;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sck_i};
      ss_q   <= {ss_q[1:0], ss_n_i};
      mosi_q <= {mosi_q[0], mosi_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_master <= 1'b0;
      ph        <= 1'b0;
    end else if (bus_sel && bus_we && bus_addr == 2'd0) begin
      is_master <= bus_wdata[0];
      ph        <= bus_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0;
      hc     <= '0;
      ecnt   <= '0;
      sck_o  <= 1'b0;
    end else if (load && is_master) begin
      m_busy <= 1'b1;
      hc     <= HW'(DIV - 1);
      ecnt   <= '0;
      sck_o  <= 1'b0;
    end else if (m_busy) begin
      if (tick) begin
        hc    <= HW'(DIV - 1);
        sck_o <= ~sck_o;
        ecnt  <= ecnt + 4'd1;
        if (ecnt == 4'd15) m_busy <= 1'b0;
      end else begin
        hc <= hc - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      obit   <= 1'b0;
      bitcnt <= '0;
      s_busy <= 1'b0;
      rxbuf  <= '0;
    end else begin
      if (load) begin
        sh <= bus_wdata;
        if (!ph) obit <= bus_wdata[7];
        if (is_master) bitcnt <= '0;
      end else begin
        if (sample) begin
          sh     <= {sh[6:0], din};
          bitcnt <= bitcnt + 3'd1;
        end
        if (launch) obit <= sh[7];
        else if (!is_master && ph && ss_fall) obit <= 1'b0;
      end
      if (done) rxbuf <= {sh[6:0], din};
      if (!is_master && ss_s) begin
        bitcnt <= '0;
        s_busy <= 1'b0;
      end else if (!is_master && lead) s_busy <= 1'b1;
      else if (done) s_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spif  <= 1'b0;
      wcol  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (bus_sel) armed <= srd & (spif | wcol);
      if (done) spif <= 1'b1;
      else if (drd && armed) spif <= 1'b0;
      if (coll) wcol <= 1'b1;
      else if (drd && armed) wcol <= 1'b0;
    end
  end

  a_r2_coll_sets_wcol: assert property (@(posedge clk) disable iff (!rst_n)
    coll |=> wcol);
  a_r3_done_sets_spif: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> spif);
  a_r3_rx_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(rxbuf));
  a_r6_ss_alone_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && ph && ss_fall && !launch) |=> !miso_o);
  a_r4_wcol_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wcol) && !$past(done)) |-> $stable(irq));
  a_r8_write_keeps_wcol: assert property (@(posedge clk) disable iff (!rst_n)
    (wcol && bus_sel && bus_we) |=> wcol);
endmodule

// File: tb/test_spi_wcol_ctl.sv
module test_spi_wcol_ctl;
  localparam int DIV = 4;
  localparam int H = 8;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic irq, sck_o, mosi_o, miso_o;
  logic sck_i = 0, mosi_i = 0, ss_n_i = 1;
  logic miso_i;
  int checks = 0, errors = 0;
  logic mcpha = 0;
  logic [7:0] mcap = 0, scap, rd;

  assign miso_i = mosi_o;
  always #10 clk = ~clk;

  spi_wcol_ctl #(.DIV(DIV)) i_spi_wcol_ctl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i),
    .sck_i(sck_i), .mosi_i(mosi_i), .ss_n_i(ss_n_i), .miso_o(miso_o));

  always @(posedge sck_o) if (!mcpha) mcap <= {mcap[6:0], mosi_o};
  always @(negedge sck_o) if (mcpha) mcap <= {mcap[6:0], mosi_o};

  localparam logic [8:0] VEC [6] = '{
    {1'b0, 8'hA5}, {1'b0, 8'h01}, {1'b0, 8'h80},
    {1'b1, 8'h5A}, {1'b1, 8'hFF}, {1'b1, 8'h37}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [1:0] a, input logic [7:0] d,
                     output logic [7:0] r);
    @(negedge clk);
    bus_sel = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    #1 r = bus_rdata;
    @(posedge clk);
    #1 bus_sel = 0; bus_we = 0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sxfer(input logic cp, input logic [7:0] b, output logic [7:0] cap);
    for (int i = 7; i >= 0; i--) begin
      if (!cp) mosi_i = b[i];
      wait_clk(H);
      sck_i = 1;
      if (cp) mosi_i = b[i];
      else cap = {cap[6:0], miso_o};
      wait_clk(H);
      sck_i = 0;
      if (cp) cap = {cap[6:0], miso_o};
    end
    wait_clk(H);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    wait_clk(3);
    chk("R9 sck", sck_o, 0); chk("R9 irq", irq, 0); chk("R9 miso", miso_o, 0);
    rst_n = 1;
    wait_clk(2);
    acc(0, 2'd0, 0, r); chk("R9 ctrl", r, 0);
    acc(0, 2'd1, 0, r); chk("R9 status", r, 0);

    foreach (VEC[k]) begin
      mcpha = VEC[k][8];
      acc(1, 2'd0, {6'b0, VEC[k][8], 1'b1}, r);
      acc(1, 2'd2, VEC[k][7:0], r);
      wait_clk(16 * DIV + 8);
      chk("R1 mosi byte", mcap, VEC[k][7:0]);
      chk("R4 irq", irq, 1);
      acc(0, 2'd1, 0, r); chk("R3 spif", r, 8'h80);
      acc(0, 2'd2, 0, r); chk("R3 rx", r, VEC[k][7:0]);
      acc(0, 2'd1, 0, r); chk("R7 cleared", r, 0);
    end

    // R2 master collision mid-transfer, R4 no irq from wcol
    mcpha = 0;
    acc(1, 2'd0, 8'h01, r);
    acc(1, 2'd2, 8'h5A, r);
    wait_clk(5 * DIV);
    acc(1, 2'd2, 8'hFF, r);
    wait_clk(1);
    chk("R4 irq low on wcol", irq, 0);
    acc(0, 2'd1, 0, r); chk("R2 wcol mid", r, 8'h40);
    acc(0, 2'd2, 0, r);
    acc(0, 2'd1, 0, r); chk("R7 clear before done", r, 0);
    acc(1, 2'd2, 8'h11, r);
    wait_clk(16 * DIV + 8);
    chk("R2 original byte", mcap, 8'h5A);
    acc(0, 2'd1, 0, r); chk("R2 wcol+spif", r, 8'hC0);
    acc(0, 2'd2, 0, r); chk("R2 rx", r, 8'h5A);

    // R8 data write as second step
    mcpha = 0;
    acc(1, 2'd2, 8'h22, r);
    wait_clk(3);
    acc(1, 2'd2, 8'h33, r);
    wait_clk(16 * DIV + 8);
    acc(0, 2'd1, 0, r); chk("R8 setup", r, 8'hC0);
    acc(1, 2'd2, 8'h44, r);
    acc(0, 2'd2, 0, r);
    acc(0, 2'd1, 0, r); chk("R8 write step", r[6], 1);
    wait_clk(16 * DIV + 8);
    acc(0, 2'd1, 0, r);
    acc(0, 2'd0, 0, r);
    acc(0, 2'd2, 0, r);
    acc(0, 2'd1, 0, r); chk("R8 other access", r, 8'hC0);
    acc(0, 2'd2, 0, r);
    acc(0, 2'd1, 0, r); chk("R7 final clear", r, 0);

    // R5 slave phase 0
    acc(1, 2'd0, 8'h00, r);
    acc(1, 2'd2, 8'hA5, r);
    acc(0, 2'd1, 0, r); chk("R5 write ss high", r, 0);
    ss_n_i = 0;
    wait_clk(6);
    chk("R5 msb on select", miso_o, 1);
    acc(1, 2'd2, 8'h11, r);
    acc(0, 2'd1, 0, r); chk("R5 write ss low", r, 8'h40);
    sxfer(0, 8'h3C, scap);
    chk("R5 miso byte", scap, 8'hA5);
    ss_n_i = 1;
    wait_clk(6);
    acc(0, 2'd1, 0, r); chk("R3 slave flags", r, 8'hC0);
    acc(0, 2'd2, 0, r); chk("R3 slave rx", r, 8'h3C);

    // R6 slave phase 1
    acc(1, 2'd0, 8'h02, r);
    ss_n_i = 0;
    wait_clk(6);
    acc(1, 2'd2, 8'h81, r);
    acc(0, 2'd1, 0, r); chk("R6 write before edge", r, 0);
    chk("R6 ss alone", miso_o, 0);
    fork
      sxfer(1, 8'hC3, scap);
      begin wait_clk(H + 5); acc(1, 2'd2, 8'h7E, r); end
    join
    chk("R6 miso byte", scap, 8'h81);
    ss_n_i = 1;
    wait_clk(6);
    acc(0, 2'd1, 0, r); chk("R6 wcol after edge", r, 8'hC0);
    acc(0, 2'd2, 0, r); chk("R6 rx", r, 8'hC3);
    acc(0, 2'd1, 0, r); chk("R7 slave clear", r, 0);
    finish_run();
  end
endmodule